// File: doc/BRIEF.md
# Dual-Network Short-Packet Interface

This block sits between a processor's memory-mapped bus and two independent, identical packet networks. By convention one network carries requests and the other carries replies, so a reply never waits behind a request. One-way traffic may use either network. Software composes a short packet by writing words to a per-network append address. The first word names the destination node and the second holds the handler address that the receiver dispatches to. Any further words are arguments. The last word goes to a separate commit address, and that write launches the packet.

If the network is backed up at the moment of commit, the packet is thrown away and a shared send-ok flag is cleared, so software must retry the send. An abort input models a process switch during composition. It discards any half-built packet and also clears send-ok. On the receive side, each network pushes words into its own incoming FIFO. Software polls a status word to learn which FIFOs hold a complete packet, then reads that packet word by word through a fixed address. Each read pops one word.

Top module: `pni_dual_net`

## Requirements
- R1: After reset, send-ok is 1, no receive packet is pending, `tx_valid` is 0 and `rx_ready` is all ones.
- R2: A write to address 2n appends a word to network n's packet. A write to address 2n+1 appends the final word and commits the packet. On the clock after that commit write, `tx_valid[n]` is high for exactly one cycle. `tx_len` then gives the word count, and word i lies at bits [(n*MAX_WORDS+i)*32 +: 32] of `tx_data`. Word 0 is the destination and word 1 is the handler address.
- R3: A commit while `tx_ready[n]` is low discards the packet with no launch and clears send-ok. A successful launch sets send-ok to 1.
- R4: `comp_abort` discards any partial packet on both networks and clears send-ok. An abort in the same cycle as a commit wins, and nothing is launched.
- R5: A commit whose packet would hold fewer than 2 words or more than MAX_WORDS words (default 6) is discarded, with send-ok cleared.
- R6: A read of address 6 returns the status word. Bit 0 is send-ok, bit 1 is set when network 0 holds a complete packet, bit 2 does the same for network 1, and all other bits are 0.
- R7: A read of address 4+n returns network n's oldest word and pops it. Popping a packet's last word moves on to the next packet. While no complete packet is held, the read returns 0 and pops nothing, so a partly arrived packet stays invisible.
- R8: Each incoming FIFO holds RX_PKTS maximum-size packets (default 4x6 words). When it is full, `rx_ready[n]` drops and an offered word is not taken. No accepted word is ever lost.
- R9: Popping a packet's last word in the same cycle as the arrival of another packet's last word leaves the pending-packet count unchanged.
- R10: Composition on one network is unaffected by writes and commits on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Bus write strobe |
| cpu_re | input | 1 | Bus read strobe (pops on receive addresses) |
| cpu_addr | input | 3 | Word address: 0..3 send, 4..5 receive, 6 status |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data (combinational from address) |
| comp_abort | input | 1 | Interrupted composition: discard partial packets |
| tx_ready | input | 2 | Per network: not backed up |
| tx_valid | output | 2 | Per network: one-cycle launch pulse |
| tx_len | output | 2*LEN_W | Per network: launched word count |
| tx_data | output | 2*MAX_WORDS*DATA_W | Per network: launched packet words |
| rx_valid | input | 2 | Per network: incoming word offered |
| rx_data | input | 2*DATA_W | Per network: incoming word |
| rx_last | input | 2 | Per network: word ends its packet |
| rx_ready | output | 2 | Per network: FIFO can take a word |

## Verification
Two receive-side events can fall in the same cycle: the processor popping the final word of one packet, and the network delivering the final word of the next one. The bench provokes this by driving the read of a packet's closing word and an incoming closing word on the same clock edge. It judges the result by the status bit, which must stay set, and by reading out the second packet intact. On the send side, an abort and a commit are also driven together, and the bench confirms that no launch follows.

// File: rtl/pni_pkg.sv
package pni_pkg;
  localparam int NETS = 2;

  typedef enum logic [2:0] {
    ADR_TX0_WORD = 3'd0,
    ADR_TX0_LAST = 3'd1,
    ADR_TX1_WORD = 3'd2,
    ADR_TX1_LAST = 3'd3,
    ADR_RX0      = 3'd4,
    ADR_RX1      = 3'd5,
    ADR_STATUS   = 3'd6,
    ADR_SPARE    = 3'd7
  } pni_addr_e;

  localparam int STAT_SEND_OK = 0;
  localparam int STAT_RX_BASE = 1;
endpackage

// File: rtl/pni_tx_compose.sv
module pni_tx_compose #(
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 6,
  parameter int LEN_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          wr_last,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          abort,
  input  logic                          net_ready,
  output logic                          commit_evt,
  output logic                          commit_ok,
  output logic                          launch,
  output logic [LEN_W-1:0]              pkt_len,
  output logic [MAX_WORDS*DATA_W-1:0]   pkt_data
);
  localparam logic [LEN_W-1:0] FULL_CNT = LEN_W'(MAX_WORDS);
  localparam logic [LEN_W-1:0] MIN_LEN  = LEN_W'(2);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             launch_d;
  logic [LEN_W-1:0] len_d;
  logic             room;
  logic             store_en;
  logic [LEN_W-1:0] cnt_plus;

  assign room       = (cnt_q < FULL_CNT);
  assign cnt_plus   = cnt_q + LEN_W'(1);
  assign store_en   = wr_en && !abort && room;
  assign commit_evt = wr_en && wr_last && !abort;
  assign commit_ok  = commit_evt && !ovf_q && room && (cnt_plus >= MIN_LEN) && net_ready;

  always_comb begin
    cnt_d    = cnt_q;
    ovf_d    = ovf_q;
    launch_d = commit_ok;
    len_d    = pkt_len;
    if (abort) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (wr_en) begin
      if (wr_last) begin
        cnt_d = '0;
        ovf_d = 1'b0;
        if (commit_ok) len_d = cnt_plus;
      end else if (room) begin
        cnt_d = cnt_plus;
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      launch  <= 1'b0;
      pkt_len <= '0;
    end else begin
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
      launch  <= launch_d;
      pkt_len <= len_d;
    end
  end

  for (genvar i = 0; i < MAX_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pkt_data[i*DATA_W +: DATA_W] <= '0;
      end else if (store_en && (cnt_q == LEN_W'(i))) begin
        pkt_data[i*DATA_W +: DATA_W] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/pni_rx_fifo.sv
module pni_rx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head_data,
  output logic              pkt_avail
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_data [DEPTH];
  logic              mem_last [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  words_q, words_d, pkts_q, pkts_d;
  logic              push, pop, push_end, pop_end;

  assign in_ready  = (words_q != CNT_W'(DEPTH));
  assign pkt_avail = (pkts_q != '0);
  assign push      = in_valid && in_ready;
  assign pop       = pop_req && pkt_avail;
  assign push_end  = push && in_last;
  assign pop_end   = pop && mem_last[rd_q];
  assign head_data = pkt_avail ? mem_data[rd_q] : '0;

  always_comb begin
    wr_d    = wr_q;
    rd_d    = rd_q;
    words_d = words_q;
    pkts_d  = pkts_q;
    if (push) wr_d = (wr_q == LAST_IDX) ? '0 : wr_q + PTR_W'(1);
    if (pop)  rd_d = (rd_q == LAST_IDX) ? '0 : rd_q + PTR_W'(1);
    case ({push, pop})
      2'b10:   words_d = words_q + CNT_W'(1);
      2'b01:   words_d = words_q - CNT_W'(1);
      default: words_d = words_q;
    endcase
    case ({push_end, pop_end})
      2'b10:   pkts_d = pkts_q + CNT_W'(1);
      2'b01:   pkts_d = pkts_q - CNT_W'(1);
      default: pkts_d = pkts_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      words_q <= '0;
      pkts_q  <= '0;
    end else begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      words_q <= words_d;
      pkts_q  <= pkts_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_data[i] <= '0;
        mem_last[i] <= 1'b0;
      end else if (push && (wr_q == PTR_W'(i))) begin
        mem_data[i] <= in_data;
        mem_last[i] <= in_last;
      end
    end
  end
endmodule

// File: rtl/pni_dual_net.sv
module pni_dual_net
  import pni_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 6,
  parameter int RX_PKTS   = 4,
  parameter int LEN_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cpu_we,
  input  logic                               cpu_re,
  input  logic [2:0]                         cpu_addr,
  input  logic [DATA_W-1:0]                  cpu_wdata,
  output logic [DATA_W-1:0]                  cpu_rdata,
  input  logic                               comp_abort,
  input  logic [NETS-1:0]                    tx_ready,
  output logic [NETS-1:0]                    tx_valid,
  output logic [NETS*LEN_W-1:0]              tx_len,
  output logic [NETS*MAX_WORDS*DATA_W-1:0]   tx_data,
  input  logic [NETS-1:0]                    rx_valid,
  input  logic [NETS*DATA_W-1:0]             rx_data,
  input  logic [NETS-1:0]                    rx_last,
  output logic [NETS-1:0]                    rx_ready
);
  localparam int RX_DEPTH = RX_PKTS * MAX_WORDS;

  logic [NETS-1:0]   commit_evt, commit_ok, pending;
  logic [DATA_W-1:0] head [NETS];
  logic              send_ok_q, send_ok_d;

  for (genvar n = 0; n < NETS; n++) begin : g_net
    logic wr_sel, pop_sel;
    assign wr_sel  = cpu_we && (cpu_addr[2:1] == 2'(n));
    assign pop_sel = cpu_re && (cpu_addr == 3'(ADR_RX0) + 3'(n));

    pni_tx_compose #(
      .DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)
    ) i_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_sel),
      .wr_last    (cpu_addr[0]),
      .wr_data    (cpu_wdata),
      .abort      (comp_abort),
      .net_ready  (tx_ready[n]),
      .commit_evt (commit_evt[n]),
      .commit_ok  (commit_ok[n]),
      .launch     (tx_valid[n]),
      .pkt_len    (tx_len[n*LEN_W +: LEN_W]),
      .pkt_data   (tx_data[n*MAX_WORDS*DATA_W +: MAX_WORDS*DATA_W])
    );

    pni_rx_fifo #(
      .DATA_W(DATA_W), .DEPTH(RX_DEPTH)
    ) i_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (rx_valid[n]),
      .in_data   (rx_data[n*DATA_W +: DATA_W]),
      .in_last   (rx_last[n]),
      .in_ready  (rx_ready[n]),
      .pop_req   (pop_sel),
      .head_data (head[n]),
      .pkt_avail (pending[n])
    );
  end

  always_comb begin
    send_ok_d = send_ok_q;
    if (comp_abort) begin
      send_ok_d = 1'b0;
    end else begin
      for (int n = 0; n < NETS; n++) begin
        if (commit_evt[n]) send_ok_d = commit_ok[n];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) send_ok_q <= 1'b1;
    else        send_ok_q <= send_ok_d;
  end

  always_comb begin
    cpu_rdata = '0;
    case (pni_addr_e'(cpu_addr))
      ADR_RX0:    cpu_rdata = head[0];
      ADR_RX1:    cpu_rdata = head[1];
      ADR_STATUS: begin
        cpu_rdata[STAT_SEND_OK] = send_ok_q;
        cpu_rdata[STAT_RX_BASE +: NETS] = pending;
      end
      default:    cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pni_dual_net_chk.sv
module pni_dual_net_chk #(
  parameter int MAX_WORDS = 6,
  parameter int LEN_W     = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               comp_abort,
  input logic [1:0]         tx_ready,
  input logic [1:0]         tx_valid,
  input logic [2*LEN_W-1:0] tx_len
);
  p_one_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_valid));

  p_backed_up_net0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready[0] |=> !tx_valid[0]);

  p_backed_up_net1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready[1] |=> !tx_valid[1]);

  p_abort_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    comp_abort |=> (tx_valid == 2'b00));

  p_len_net0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid[0] |-> (tx_len[0 +: LEN_W] >= LEN_W'(2) && tx_len[0 +: LEN_W] <= LEN_W'(MAX_WORDS)));

  p_len_net1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid[1] |-> (tx_len[LEN_W +: LEN_W] >= LEN_W'(2) && tx_len[LEN_W +: LEN_W] <= LEN_W'(MAX_WORDS)));
endmodule

bind pni_dual_net pni_dual_net_chk #(
  .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .comp_abort(comp_abort),
  .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_len(tx_len)
);

// File: tb/test_pni_dual_net.sv
module test_pni_dual_net;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int MW = 6;
  localparam int LW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cpu_we = 1'b0, cpu_re = 1'b0;
  logic [2:0]      cpu_addr = '0;
  logic [DW-1:0]   cpu_wdata = '0;
  logic [DW-1:0]   cpu_rdata;
  logic            comp_abort = 1'b0;
  logic [1:0]      tx_ready = 2'b11;
  logic [1:0]      tx_valid;
  logic [2*LW-1:0] tx_len;
  logic [2*MW*DW-1:0] tx_data;
  logic [1:0]      rx_valid = 2'b00;
  logic [2*DW-1:0] rx_data = '0;
  logic [1:0]      rx_last = 2'b00;
  logic [1:0]      rx_ready;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pni_dual_net i_pni_dual_net (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .comp_abort(comp_abort), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_len(tx_len), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); cpu_re = 1'b1; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk); cpu_re = 1'b0;
  endtask

  task automatic net_push(input int n, input logic [DW-1:0] d, input bit last);
    @(negedge clk); rx_valid[n] = 1'b1; rx_data[n*DW +: DW] = d; rx_last[n] = last;
    @(negedge clk); rx_valid[n] = 1'b0; rx_last[n] = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int seed, input int i);
    return DW'(seed) * 32'h0001_0000 + DW'(i) + 32'h5A00;
  endfunction

  // Sends len words of pattern seed on net n; check happens right after the commit.
  task automatic send_pkt(input int n, input int seed, input int len);
    for (int i = 0; i < len - 1; i++) bus_write(3'(2*n), pat(seed, i));
    bus_write(3'(2*n+1), pat(seed, len - 1));
  endtask

  task automatic expect_launch(input int n, input int seed, input int len, input string tag);
    check(tx_valid == 2'(1 << n), {tag, " launch"}, 32'(tx_valid), 32'(1 << n));
    check(tx_len[n*LW +: LW] == LW'(len), {tag, " len"}, 32'(tx_len[n*LW +: LW]), 32'(len));
    for (int i = 0; i < len; i++)
      check(tx_data[(n*MW+i)*DW +: DW] == pat(seed, i), {tag, " word"},
            tx_data[(n*MW+i)*DW +: DW], pat(seed, i));
  endtask

  task automatic expect_status(input logic [DW-1:0] exp, input string tag);
    logic [DW-1:0] s;
    bus_read(3'd6, s);
    check(s == exp, tag, s, exp);
  endtask

  task automatic t_reset();
    check(tx_valid == 2'b00, "R1 tx_valid", 32'(tx_valid), 0);
    check(rx_ready == 2'b11, "R1 rx_ready", 32'(rx_ready), 3);
    expect_status(32'h1, "R1 status");
  endtask

  task automatic t_basic_send();
    send_pkt(0, 1, 4);
    expect_launch(0, 1, 4, "R2 net0");
    @(negedge clk);
    check(tx_valid == 2'b00, "R2 single pulse", 32'(tx_valid), 0);
    expect_status(32'h1, "R2 send_ok");
  endtask

  task automatic t_interleave();
    bus_write(3'd0, pat(2, 0));
    bus_write(3'd0, pat(2, 1));
    send_pkt(1, 3, 6);
    expect_launch(1, 3, 6, "R10 net1 full");
    bus_write(3'd1, pat(2, 2));
    expect_launch(0, 2, 3, "R10 net0 resumed");
  endtask

  task automatic t_backpressure();
    tx_ready = 2'b10;
    send_pkt(0, 4, 3);
    check(tx_valid == 2'b00, "R3 dropped", 32'(tx_valid), 0);
    expect_status(32'h0, "R3 send_ok low");
    tx_ready = 2'b11;
    send_pkt(0, 4, 3);
    expect_launch(0, 4, 3, "R3 retry");
    expect_status(32'h1, "R3 send_ok high");
  endtask

  task automatic t_abort();
    bus_write(3'd2, pat(9, 0));
    bus_write(3'd2, pat(9, 1));
    @(negedge clk); comp_abort = 1'b1;
    @(negedge clk); comp_abort = 1'b0;
    expect_status(32'h0, "R4 abort clears send_ok");
    send_pkt(1, 5, 3);
    expect_launch(1, 5, 3, "R4 restart after abort");
    bus_write(3'd0, pat(6, 0));
    @(negedge clk); cpu_we = 1'b1; cpu_addr = 3'd1; cpu_wdata = pat(6, 1); comp_abort = 1'b1;
    @(negedge clk); cpu_we = 1'b0; comp_abort = 1'b0;
    check(tx_valid == 2'b00, "R4 abort beats commit", 32'(tx_valid), 0);
    expect_status(32'h0, "R4 send_ok after clash");
  endtask

  task automatic t_length();
    send_pkt(0, 7, 1);
    check(tx_valid == 2'b00, "R5 one word dropped", 32'(tx_valid), 0);
    send_pkt(0, 7, 2);
    expect_launch(0, 7, 2, "R5 two words ok");
    send_pkt(1, 8, 7);
    check(tx_valid == 2'b00, "R5 seven words dropped", 32'(tx_valid), 0);
    expect_status(32'h0, "R5 send_ok low");
    send_pkt(1, 8, 6);
    expect_launch(1, 8, 6, "R5 six words ok");
  endtask

  task automatic t_receive();
    logic [DW-1:0] d;
    net_push(1, pat(20, 0), 1'b0);
    net_push(1, pat(20, 1), 1'b0);
    expect_status(32'h1, "R7 partial invisible");
    bus_read(3'd5, d);
    check(d == 0, "R7 empty read", d, 0);
    net_push(1, pat(20, 2), 1'b1);
    expect_status(32'h5, "R6 net1 pending");
    for (int i = 0; i < 3; i++) begin
      bus_read(3'd5, d);
      check(d == pat(20, i), "R7 read word", d, pat(20, i));
    end
    expect_status(32'h1, "R7 drained");
  endtask

  task automatic t_fill();
    logic [DW-1:0] d;
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < MW; i++) net_push(0, pat(30 + p, i), i == MW - 1);
    check(rx_ready == 2'b10, "R8 full holds off", 32'(rx_ready), 2);
    net_push(0, 32'hDEAD_BEEF, 1'b1);
    expect_status(32'h3, "R6 net0 pending");
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < MW; i++) begin
        bus_read(3'd4, d);
        check(d == pat(30 + p, i), "R8 stored word", d, pat(30 + p, i));
      end
    expect_status(32'h1, "R8 extra word not taken");
    check(rx_ready == 2'b11, "R8 ready again", 32'(rx_ready), 3);
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] d;
    net_push(0, pat(40, 0), 1'b0);
    net_push(0, pat(40, 1), 1'b1);
    net_push(0, pat(41, 0), 1'b0);
    bus_read(3'd4, d);
    check(d == pat(40, 0), "R9 first word", d, pat(40, 0));
    @(negedge clk);
    cpu_re = 1'b1; cpu_addr = 3'd4;
    rx_valid[0] = 1'b1; rx_data[DW-1:0] = pat(41, 1); rx_last[0] = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_re = 1'b0; rx_valid[0] = 1'b0; rx_last[0] = 1'b0;
    check(d == pat(40, 1), "R9 popped last", d, pat(40, 1));
    expect_status(32'h3, "R9 still one pending");
    for (int i = 0; i < 2; i++) begin
      bus_read(3'd4, d);
      check(d == pat(41, i), "R9 second packet", d, pat(41, i));
    end
    expect_status(32'h1, "R9 drained");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_send();
    t_interleave();
    t_backpressure();
    t_abort();
    t_length();
    t_receive();
    t_fill();
    t_same_cycle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule